// File: doc/BRIEF.md
# Vector Memory Access Legality Checker

This block judges whether a vector load or store instruction may execute under the current vector configuration. It takes the element width encoded in the instruction, the configured element width and register-group multiplier (fractional values included), the data and index register numbers, the field count, the mask bit and three form flags. From these it derives the effective group multiplier of the accessed data. It then applies range, alignment, register-budget, segment, overlap and mask-destination rules.

It sits beside an instruction decoder. Each cycle the decoder raises `chk_valid`, and one clock later the block returns a pulse on `res_valid` together with an illegal-instruction flag and a one-hot cause. Widths are coded as 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. The multiplier is a signed log2 value, from -3 (one eighth) to +3 (eight), and -4 is a reserved code. The field count is given as count minus one. The effective multiplier is handled as `emul_log2 = eew_log2 - sew_log2 + lmul_log2`. Below, G(x) means max(2^x, 1).

Top module: `vmem_legality_check`

## Requirements
- R1: `cause[0]` is set when the multiplier code is the reserved value -4, or when the effective multiplier log2 lies outside -3..+3.
- R2: For non-indexed forms with an effective multiplier log2 above 0, a data register number that is not a multiple of 2^emul_log2 sets `cause[1]`.
- R3: For indexed forms, a data register that is not a multiple of G(lmul_log2), or an index register that is not a multiple of G(emul_log2), sets `cause[1]`.
- R4: The data group size is G(emul_log2) for non-indexed forms and G(lmul_log2) for indexed forms. `cause[2]` is set when the field count times this size exceeds 8, or when the data register plus that product exceeds 32.
- R5: A field count above 1 with `seg_ok` low sets `cause[3]`.
- R6: For an indexed load where emul_log2 differs from lmul_log2, or where the field count is above 1, `cause[4]` is set if the index range [idx_reg, idx_reg + G(emul_log2)) intersects the data span. The data span starts at the data register and has length G(lmul_log2) times the field count. Indexed stores never raise this cause.
- R7: A load with `vm` low (masked) whose data register is 0 sets `cause[5]`. Stores and unmasked loads never raise it.
- R8: `cause` is one-hot or zero. When several rules fail, only the lowest-numbered cause is reported. `illegal` is high exactly when `cause` is non-zero.
- R9: The result appears on the first rising edge after `chk_valid` is sampled high, with `res_valid` high for that one cycle. Without `chk_valid`, `illegal` and `cause` hold their values. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Instruction fields are valid this cycle |
| eew_code | input | 2 | Encoded element width of the access |
| sew_code | input | 2 | Configured element width |
| lmul_log2 | input | 3 | Signed log2 of configured group multiplier |
| data_reg | input | 5 | Data (destination or source) register number |
| idx_reg | input | 5 | Index register number |
| nf_m1 | input | 3 | Field count minus one |
| vm | input | 1 | Mask bit, 0 means masked |
| is_load | input | 1 | 1 for load, 0 for store |
| is_indexed | input | 1 | Indexed addressing form |
| seg_ok | input | 1 | Multi-field accesses are supported |
| res_valid | output | 1 | Result strobe |
| illegal | output | 1 | Instruction is illegal |
| cause | output | 6 | One-hot reason, bit n matches rule n+1 |

## Verification
Directed cases push each rule just past its limit and just inside it. Examples are an effective multiplier of 16 against 8, a data register of 28 against 24 with two fields of four, and a masked load to register 0 against the same store. These separate off-by-one errors in each comparison. Paired load and store cases with the same registers separate the load-only rules from the shared ones. Combinations that break two rules at once show whether priority is honoured. A long run of pseudo-random fields with a sparse valid strobe, checked every clock against a model in multiplier units, tests the arithmetic away from the hand-picked points and tests that the outputs hold between requests.

// File: rtl/vmem_legality_check.sv
module vmem_legality_check #(
  parameter int NUM_VREGS = 32,
  parameter int SPAN_MAX  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_valid,
  input  logic [1:0] eew_code,
  input  logic [1:0] sew_code,
  input  logic [2:0] lmul_log2,
  input  logic [4:0] data_reg,
  input  logic [4:0] idx_reg,
  input  logic [2:0] nf_m1,
  input  logic       vm,
  input  logic       is_load,
  input  logic       is_indexed,
  input  logic       seg_ok,
  output logic       res_valid,
  output logic       illegal,
  output logic [5:0] cause
);
  localparam int SW = $clog2(NUM_VREGS) + 2;

  logic signed [3:0] lmul_s, emul_s;
  logic [1:0] ge_log, gl_log, gd_log;
  logic [3:0] nf;
  logic [SW-1:0] span, dspan, ilen, vd_w, vs_w;
  logic bad_range, bad_align, bad_budget, bad_seg, bad_ovl, bad_mask;
  logic [5:0] cause_n;

  assign lmul_s = {lmul_log2[2], lmul_log2};
  assign emul_s = $signed({2'b00, eew_code}) - $signed({2'b00, sew_code}) + lmul_s;

  assign bad_range = (lmul_log2 == 3'b100) || (emul_s < -4'sd3) || (emul_s > 4'sd3);

  assign ge_log = (emul_s > 4'sd0) ? emul_s[1:0] : 2'd0;
  assign gl_log = (lmul_s > 4'sd0) ? lmul_s[1:0] : 2'd0;
  assign gd_log = is_indexed ? gl_log : ge_log;

  function automatic logic misaligned(input logic [4:0] r, input logic [1:0] lg);
    logic [4:0] m;
    m = (5'd1 << lg) - 5'd1;
    return (r & m) != 5'd0;
  endfunction

  assign bad_align = is_indexed ? (misaligned(data_reg, gl_log) || misaligned(idx_reg, ge_log))
                                : misaligned(data_reg, ge_log);

  assign nf   = {1'b0, nf_m1} + 4'd1;
  assign vd_w = SW'(data_reg);
  assign vs_w = SW'(idx_reg);
  assign span = SW'(nf) << gd_log;
  assign bad_budget = (span > SW'(SPAN_MAX)) || ((vd_w + span) > SW'(NUM_VREGS));

  assign bad_seg = (nf_m1 != 3'd0) && !seg_ok;

  assign dspan = (nf_m1 != 3'd0) ? span : (SW'(1) << gd_log);
  assign ilen  = SW'(1) << ge_log;
  assign bad_ovl = is_load && is_indexed && ((emul_s != lmul_s) || (nf_m1 != 3'd0)) &&
                   (vd_w < vs_w + ilen) && (vs_w < vd_w + dspan);

  assign bad_mask = is_load && !vm && (data_reg == 5'd0);

  always_comb begin
    cause_n = '0;
    if (bad_range)       cause_n[0] = 1'b1;
    else if (bad_align)  cause_n[1] = 1'b1;
    else if (bad_budget) cause_n[2] = 1'b1;
    else if (bad_seg)    cause_n[3] = 1'b1;
    else if (bad_ovl)    cause_n[4] = 1'b1;
    else if (bad_mask)   cause_n[5] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      cause     <= '0;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid) begin
        illegal <= |cause_n;
        cause   <= cause_n;
      end
    end
  end

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> (!res_valid && $stable(cause) && $stable(illegal)));
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause) && (illegal == (cause != 6'd0)));
  p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && lmul_log2 == 3'b100) |=> cause[0]);
  p_noseg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && nf_m1 != 3'd0 && !seg_ok) |=> illegal);
  p_maskdst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && is_load && !vm && data_reg == 5'd0) |=> illegal);
  p_store_ovl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !is_load) |=> !cause[4]);
endmodule

// File: tb/tb_vmem_legality_check.sv
`timescale 1ns/1ps
module tb_vmem_legality_check;
  logic clk = 1'b0, rst_n = 1'b0, chk_valid = 1'b0;
  logic [1:0] eew_code = '0, sew_code = '0;
  logic [2:0] lmul_log2 = '0, nf_m1 = '0;
  logic [4:0] data_reg = '0, idx_reg = '0;
  logic vm = 1'b1, is_load = 1'b0, is_indexed = 1'b0, seg_ok = 1'b0;
  logic res_valid, illegal;
  logic [5:0] cause;
  int total = 0, bad = 0;
  logic [5:0] exp_cause = '0;
  logic exp_valid = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vmem_legality_check dut (.*);

  function automatic logic [5:0] model(int ec, int sc, int lm, int vd, int vs, int nfm,
                                       bit m, bit ld, bit ix, bit sg);
    int eew, sew, lx, ex, ge, gl, gd, n, sp;
    eew = 8 << ec; sew = 8 << sc;
    if (lm == -4) return 6'd1;
    lx = (lm >= 0) ? (64 << lm) : (64 >> (-lm));
    ex = eew * lx / sew;
    if (ex < 8 || ex > 512) return 6'd1;
    ge = (ex >= 64) ? ex / 64 : 1;
    gl = (lx >= 64) ? lx / 64 : 1;
    n = nfm + 1;
    if (!ix) begin
      if (vd % ge != 0) return 6'd2;
    end else if ((vd % gl != 0) || (vs % ge != 0)) return 6'd2;
    gd = ix ? gl : ge;
    if (n * gd > 8 || vd + n * gd > 32) return 6'd4;
    if (n > 1 && !sg) return 6'd8;
    if (ld && ix && (ex != lx || n > 1)) begin
      sp = n * gd;
      if (vd < vs + ge && vs < vd + sp) return 6'd16;
    end
    if (ld && !m && vd == 0) return 6'd32;
    return 6'd0;
  endfunction

  function automatic string tag_of(logic [5:0] c);
    case (c)
      6'd1:  return "R1";
      6'd2:  return "R2/R3";
      6'd4:  return "R4";
      6'd8:  return "R5";
      6'd16: return "R6";
      6'd32: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_cause <= '0;
    end else begin
      exp_valid <= chk_valid;
      if (chk_valid)
        exp_cause <= model(eew_code, sew_code, $signed(lmul_log2), data_reg, idx_reg,
                           nf_m1, vm, is_load, is_indexed, seg_ok);
    end
  end

  // per-cycle comparison; R9 covers strobe timing and holding
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (res_valid !== exp_valid || illegal !== (exp_cause != 0) || cause !== exp_cause) begin
        bad++;
        $display("FAIL %s/R9: valid=%b illegal=%b cause=%b expected valid=%b illegal=%b cause=%b",
                 tag_of(exp_cause), res_valid, illegal, cause, exp_valid, exp_cause != 0, exp_cause);
      end
    end
  end

  task automatic drive(int ec, int sc, int lm, int vd, int vs, int nfm,
                       bit m, bit ld, bit ix, bit sg);
    @(negedge clk);
    chk_valid = 1'b1;
    eew_code = 2'(ec); sew_code = 2'(sc); lmul_log2 = 3'(lm);
    data_reg = 5'(vd); idx_reg = 5'(vs); nf_m1 = 3'(nfm);
    vm = m; is_load = ld; is_indexed = ix; seg_ok = sg;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++; // R9 reset state
    if (res_valid !== 1'b0 || illegal !== 1'b0 || cause !== 6'd0) begin
      bad++;
      $display("FAIL R9 reset: %b %b %b expected 0 0 000000", res_valid, illegal, cause);
    end
    rst_n = 1'b1;
    // R1 range: emul 8 legal, 16 illegal, 1/16 illegal, reserved code
    drive(3, 0, 0, 8, 0, 0, 1, 0, 0, 0);
    drive(3, 0, 1, 8, 0, 0, 1, 0, 0, 0);
    drive(0, 3, -1, 0, 0, 0, 1, 1, 0, 0);
    drive(0, 0, -4, 0, 0, 0, 1, 1, 0, 0);
    // R2 non-indexed alignment with emul 4
    drive(2, 0, 0, 2, 0, 0, 1, 0, 0, 0);
    drive(2, 0, 0, 4, 0, 0, 1, 0, 0, 0);
    // R3 indexed: lmul 2, emul 4
    drive(1, 0, 1, 1, 8, 0, 1, 0, 1, 0);
    drive(1, 0, 1, 2, 6, 0, 1, 0, 1, 0);
    drive(1, 0, 1, 2, 8, 0, 1, 0, 1, 0);
    // R4 budget
    drive(2, 0, 0, 0, 0, 3, 1, 0, 0, 1);
    drive(2, 0, 0, 28, 0, 1, 1, 0, 0, 1);
    drive(2, 0, 0, 24, 0, 1, 1, 0, 0, 1);
    // R5 segment support
    drive(0, 0, 0, 4, 0, 1, 1, 0, 0, 0);
    drive(0, 0, 0, 4, 0, 1, 1, 0, 0, 1);
    // R6 overlap on indexed loads, not stores
    drive(1, 0, 0, 4, 4, 0, 1, 1, 1, 0);
    drive(1, 0, 0, 2, 4, 0, 1, 1, 1, 0);
    drive(1, 0, 0, 4, 4, 0, 1, 0, 1, 0);
    drive(0, 0, 0, 2, 4, 2, 1, 1, 1, 1);
    drive(0, 0, 0, 2, 5, 2, 1, 1, 1, 1);
    // R7 masked load to v0
    drive(0, 0, 0, 0, 8, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 8, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 8, 0, 1, 1, 0, 0);
    // R8 priority: range beats mask; alignment beats segment
    drive(3, 0, 2, 0, 0, 0, 0, 1, 0, 0);
    drive(2, 0, 0, 1, 0, 1, 1, 0, 0, 0);
    // R9 hold across idle cycles
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chk_valid = ($urandom_range(0, 3) != 0);
      eew_code = 2'($urandom); sew_code = 2'($urandom);
      lmul_log2 = 3'($urandom); data_reg = 5'($urandom);
      idx_reg = 5'($urandom); nf_m1 = ($urandom_range(0, 1) != 0) ? 3'd0 : 3'($urandom);
      vm = 1'($urandom); is_load = 1'($urandom);
      is_indexed = 1'($urandom); seg_ok = 1'($urandom);
    end
    @(negedge clk);
    chk_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule